// File: doc/BRIEF.md
# Operational Mode Request Handshake Controller

This block sits between a small control processor and a power manager. The processor writes a requested operational mode. The block checks that the request is legal and forwards legal requests to the power manager over a request/acknowledge pair. When the power manager answers, the block records the mode it confirmed. Software must treat that recorded mode as the current operating mode.

There are four modes, encoded 0 = PDA, 1 = A, 2 = LP and 3 = PDLP. They form a linear chain in that order, and a request may move only one step along it, in either direction. The chain does not wrap, so 0 and 3 are not neighbours. A request is also refused while an earlier one is still outstanding. A refused write is not forwarded and sets a sticky error bit.

Each mode implies a supply request. The two power-down modes (0 and 3) ask for the low-current supply, and the two active modes (1 and 2) ask for the full supply. While either the requested mode or the confirmed mode is a power-down mode, a peripheral inhibit output is held high. It keeps the oscillator control, the time-to-digital converter and the ADC interface out of use while the low-current supply may be in force. The acknowledge from the power manager may arrive after any number of cycles. It passes through a parameterised synchroniser before it is used.

Top module: `opmode_handshake`

## Requirements
- R1: After reset the requested mode and the acknowledged mode are both 1 (A), and busy, the power-manager request and the error bit are all 0.
- R2: While idle, a write of a mode one chain step away from the current mode is accepted. From the next cycle the forwarded mode equals the written value, and the request and busy are both high.
- R3: When the synchronised acknowledge is seen high while the request is high, the acknowledged mode takes the requested value on the next cycle and the request goes low.
- R4: Busy stays high from acceptance until the synchronised acknowledge has returned low after the request was withdrawn. While busy is high, the forwarded mode does not change.
- R5: A write that arrives while busy is high is dropped and sets the error bit. The forwarded mode and the acknowledged mode stay unchanged.
- R6: While idle, a write that skips a chain position (distance 2, or 0 to 3 and back) is dropped, sets the error bit and raises no request.
- R7: While idle, a write of the current mode is ignored. It causes no request and no error.
- R8: The error bit is sticky and is cleared by a clear pulse. When a clear pulse and a dropped write occur in the same cycle, the bit stays set.
- R9: The supply output is high when the forwarded mode is 1 or 2, and low when it is 0 or 3.
- R10: The peripheral inhibit is high whenever the forwarded mode or the acknowledged mode is 0 or 3, and low otherwise.
- R11: The acknowledge input is used after ACK_SYNC_STAGES register stages. An acknowledge pulse while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mode request write strobe |
| wr_mode | input | 2 | Requested mode (0 PDA, 1 A, 2 LP, 3 PDLP) |
| err_clr | input | 1 | Clears the sticky error bit |
| pm_ack | input | 1 | Acknowledge from the power manager, asynchronous |
| pm_req | output | 1 | Request to the power manager |
| pm_mode | output | 2 | Mode presented with the request |
| pm_supply_active | output | 1 | 1 = full supply requested, 0 = low-current supply |
| ack_mode | output | 2 | Acknowledged (current) mode |
| busy | output | 1 | Request outstanding |
| err_flag | output | 1 | Sticky illegal-request flag |
| periph_inhibit | output | 1 | Blocks peripherals that need the full supply |

## Verification
A walk through the whole chain in both directions exercises every legal step. It shows that the forwarded and acknowledged modes track each other and that the supply and inhibit outputs follow each mode. Skipped positions, the two chain ends 0 and 3, and writes of the current mode separate a true adjacency check from a ring-distance or plain-inequality check. Writes during the request and release phases, run with power-manager latencies of 0, 3 and 7 cycles, show whether busy covers the whole four-phase exchange. A stray acknowledge pulse while idle and a clear pulse in the same cycle as a refused write expose errors in acknowledge qualification and in the priority of the error bit.

// File: rtl/opm_pkg.sv
// Package: shared mode encoding, handshake states and chain helpers for the
// operational mode request handshake controller. Assumes four modes on a
// linear (non-wrapping) chain with 2-bit codes.
package opm_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        OPM_PDA  = 2'd0,
        OPM_ACT  = 2'd1,
        OPM_LP   = 2'd2,
        OPM_PDLP = 2'd3
    } opm_mode_e;

    localparam logic [MODE_W-1:0] OPM_RESET_MODE = OPM_ACT;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_REL  = 2'd2
    } hs_state_e;

    // True when the two codes are exactly one chain position apart.
    function automatic logic opm_is_adjacent(input logic [MODE_W-1:0] a,
                                             input logic [MODE_W-1:0] b);
        logic [MODE_W:0] ea;
        logic [MODE_W:0] eb;
        ea = {1'b0, a};
        eb = {1'b0, b};
        return ((ea - eb) == 'd1) || ((eb - ea) == 'd1);
    endfunction

    // True for the two power-down modes, which draw on the low-current supply.
    function automatic logic opm_is_powerdown(input logic [MODE_W-1:0] m);
        return (m == OPM_PDA) || (m == OPM_PDLP);
    endfunction

endpackage

// File: rtl/opm_step_check.sv
// Module: opm_step_check
// Classifies a mode write as accepted, ignored or refused. Assumes cur_mode is
// the mode currently forwarded (equal to the acknowledged mode when idle).
// Purely combinational.
module opm_step_check
    import opm_pkg::*;
(
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic              busy,
    output logic              accept,
    output logic              reject
);

    logic adjacent;
    logic same;

    // Purpose: decide whether the write moves exactly one chain step.
    always_comb begin
        adjacent = opm_is_adjacent(wr_mode, cur_mode);
        same     = (wr_mode == cur_mode);
    end

    // Purpose: produce accept/refuse strobes; same-mode writes when idle do neither.
    always_comb begin
        accept = 1'b0;
        reject = 1'b0;
        if (wr_en) begin
            if (busy) begin
                reject = 1'b1;
            end else if (adjacent) begin
                accept = 1'b1;
            end else if (!same) begin
                reject = 1'b1;
            end
        end
    end

endmodule

// File: rtl/opm_ack_sync.sv
// Module: opm_ack_sync
// Brings the asynchronous acknowledge from the power manager into the clock
// domain through STAGES flip-flops. STAGES = 0 passes it straight through and
// assumes the source is already synchronous.
module opm_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign ack_out = ack_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;

            // Purpose: shift the acknowledge through the synchroniser stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], ack_in};
                end
            end

            assign ack_out = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/opm_handshake_fsm.sv
// Module: opm_handshake_fsm
// Holds the requested and acknowledged modes and runs a four-phase exchange
// with the power manager: raise the request, wait for the acknowledge, drop the
// request, wait for the acknowledge to drop. Assumes accept only pulses while
// the FSM is idle.
module opm_handshake_fsm
    import opm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [MODE_W-1:0] new_mode,
    input  logic              ack_s,
    output logic [MODE_W-1:0] req_mode,
    output logic [MODE_W-1:0] cur_ack_mode,
    output logic              req_out,
    output logic              busy_out
);

    hs_state_e         state_q;
    hs_state_e         state_d;
    logic [MODE_W-1:0] req_q;
    logic [MODE_W-1:0] ack_q;

    // Purpose: next-state logic of the four-phase exchange.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (accept) state_d = HS_REQ;
            HS_REQ:  if (ack_s)  state_d = HS_REL;
            HS_REL:  if (!ack_s) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Purpose: capture the requested mode when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= OPM_RESET_MODE;
        end else if (state_q == HS_IDLE && accept) begin
            req_q <= new_mode;
        end
    end

    // Purpose: record the confirmed mode when the acknowledge arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= OPM_RESET_MODE;
        end else if (state_q == HS_REQ && ack_s) begin
            ack_q <= req_q;
        end
    end

    assign req_mode     = req_q;
    assign cur_ack_mode = ack_q;
    assign req_out      = (state_q == HS_REQ);
    assign busy_out     = (state_q != HS_IDLE);

endmodule

// File: rtl/opm_supply_map.sv
// Module: opm_supply_map
// Maps modes to the supply request and the peripheral inhibit. The inhibit is
// conservative: it is held while either the requested or the confirmed mode
// may leave the low-current supply in force. Purely combinational.
module opm_supply_map
    import opm_pkg::*;
(
    input  logic [MODE_W-1:0] req_mode,
    input  logic [MODE_W-1:0] conf_mode,
    output logic              supply_active,
    output logic              inhibit
);

    // Purpose: derive supply request and inhibit from the two modes.
    always_comb begin
        supply_active = !opm_is_powerdown(req_mode);
        inhibit       = opm_is_powerdown(req_mode) || opm_is_powerdown(conf_mode);
    end

endmodule

// File: rtl/opmode_handshake.sv
// Module: opmode_handshake (top)
// Accepts mode writes from the control processor, forwards legal single-step
// requests to the power manager and records the acknowledged mode. Refused
// writes set a sticky error bit. Assumes the power manager follows a
// four-phase exchange: it holds the acknowledge until the request drops.
module opmode_handshake
    import opm_pkg::*;
#(
    parameter int ACK_SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              err_clr,
    input  logic              pm_ack,
    output logic              pm_req,
    output logic [MODE_W-1:0] pm_mode,
    output logic              pm_supply_active,
    output logic [MODE_W-1:0] ack_mode,
    output logic              busy,
    output logic              err_flag,
    output logic              periph_inhibit
);

    logic              accept;
    logic              reject;
    logic              ack_s;
    logic [MODE_W-1:0] req_mode;
    logic [MODE_W-1:0] conf_mode;
    logic              req_int;
    logic              busy_int;
    logic              err_q;

    opm_step_check u_check (
        .wr_en    (wr_en),
        .wr_mode  (wr_mode),
        .cur_mode (req_mode),
        .busy     (busy_int),
        .accept   (accept),
        .reject   (reject)
    );

    opm_ack_sync #(.STAGES(ACK_SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_in  (pm_ack),
        .ack_out (ack_s)
    );

    opm_handshake_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .new_mode     (wr_mode),
        .ack_s        (ack_s),
        .req_mode     (req_mode),
        .cur_ack_mode (conf_mode),
        .req_out      (req_int),
        .busy_out     (busy_int)
    );

    opm_supply_map u_map (
        .req_mode      (req_mode),
        .conf_mode     (conf_mode),
        .supply_active (pm_supply_active),
        .inhibit       (periph_inhibit)
    );

    // Purpose: sticky error bit; a refusal in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (reject) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign pm_req   = req_int;
    assign pm_mode  = req_mode;
    assign ack_mode = conf_mode;
    assign busy     = busy_int;
    assign err_flag = err_q;

endmodule

// File: rtl/opmode_handshake_chk.sv
// Module: opmode_handshake_chk
// Assertion checker bound to opmode_handshake; observes its ports only.
module opmode_handshake_chk
    import opm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              err_clr,
    input logic              pm_req,
    input logic [MODE_W-1:0] pm_mode,
    input logic              pm_supply_active,
    input logic [MODE_W-1:0] ack_mode,
    input logic              busy,
    input logic              err_flag,
    input logic              periph_inhibit
);

    // R4: the forwarded mode is frozen while a request is outstanding.
    a_r4_mode_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pm_mode));

    // R3: once idle again, the confirmed mode matches the forwarded one.
    a_r3_idle_modes_agree: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ack_mode == pm_mode));

    // R2: a new request always starts one chain step from the confirmed mode.
    a_r2_request_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pm_req) |-> opm_is_adjacent(pm_mode, ack_mode));

    // R8: the error bit only falls after a clear pulse.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(err_flag)) |-> $past(err_clr));

    // R10: a low-current supply request always comes with the inhibit.
    a_r10_inhibit_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_supply_active |-> periph_inhibit);

    // R4: the request is never raised without busy.
    a_r4_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req |-> busy);

endmodule

bind opmode_handshake opmode_handshake_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .err_clr          (err_clr),
    .pm_req           (pm_req),
    .pm_mode          (pm_mode),
    .pm_supply_active (pm_supply_active),
    .ack_mode         (ack_mode),
    .busy             (busy),
    .err_flag         (err_flag),
    .periph_inhibit   (periph_inhibit)
);

// File: tb/opmode_handshake_test.sv
// Bench: behavioural reference model compared with the design on every clock.
module opmode_handshake_test;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_mode = 2'd0;
    logic       err_clr = 1'b0;
    logic       pm_ack;
    logic       pm_req;
    logic [1:0] pm_mode;
    logic       pm_supply_active;
    logic [1:0] ack_mode;
    logic       busy;
    logic       err_flag;
    logic       periph_inhibit;

    logic pm_ack_model = 1'b0;
    logic poke = 1'b0;
    assign pm_ack = pm_ack_model | poke;

    int n_checks = 0;
    int n_fail = 0;
    int lat = 3;
    int wait_cnt = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_req = 1, m_ack = 1, m_phase = 0, m_err = 0;
    bit m_pipe [0:7];

    opmode_handshake #(.ACK_SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
        .err_clr(err_clr), .pm_ack(pm_ack), .pm_req(pm_req), .pm_mode(pm_mode),
        .pm_supply_active(pm_supply_active), .ack_mode(ack_mode), .busy(busy),
        .err_flag(err_flag), .periph_inhibit(periph_inhibit)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit adj(input int a, input int b);
        return (a - b == 1) || (b - a == 1);
    endfunction

    function automatic bit pd(input int m);
        return (m == 0) || (m == 3);
    endfunction

    // model update at each edge, from inputs that were stable before it
    always @(posedge clk) begin
        bit s, acc, rej;
        cycles++;
        if (!rst_n) begin
            m_req = 1; m_ack = 1; m_phase = 0; m_err = 0;
            for (int i = 0; i < 8; i++) m_pipe[i] = 0;
        end else begin
            s = (SYNC == 0) ? pm_ack : m_pipe[SYNC-1];
            for (int i = 7; i > 0; i--) m_pipe[i] = m_pipe[i-1];
            m_pipe[0] = pm_ack;
            acc = wr_en && m_phase == 0 && adj(wr_mode, m_req);
            rej = wr_en && (m_phase != 0 || (!adj(wr_mode, m_req) && wr_mode != m_req));
            if (rej) m_err = 1; else if (err_clr) m_err = 0;
            case (m_phase)
                0: if (acc) begin m_req = wr_mode; m_phase = 1; end
                1: if (s) begin m_ack = m_req; m_phase = 2; end
                default: if (!s) m_phase = 0;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 ack_mode", ack_mode, m_ack);
            chk("R2 pm_mode", pm_mode, m_req);
            chk("R3 pm_req", pm_req, m_phase == 1);
            chk("R4 busy", busy, m_phase != 0);
            chk("R8 err_flag", err_flag, m_err);
            chk("R9 supply", pm_supply_active, !pd(m_req));
            chk("R10 inhibit", periph_inhibit, pd(m_req) || pd(m_ack));
        end
    end

    // power manager: acknowledge after lat cycles, release when request drops
    always @(negedge clk) begin
        if (!rst_n) begin
            pm_ack_model = 0; wait_cnt = 0;
        end else if (pm_req) begin
            if (wait_cnt >= lat) pm_ack_model = 1;
            wait_cnt++;
        end else begin
            pm_ack_model = 0; wait_cnt = 0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected 0", cycles);
            summary();
        end
    end

    task automatic wr(input int m);
        @(negedge clk);
        wr_en = 1; wr_mode = 2'(m);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic step(input int m);
        wr(m);
        chk("R2 accepted busy", busy, 1);
        wait_idle();
        chk("R3 confirmed mode", ack_mode, m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ack reset", ack_mode, 1);
        chk("R1 req reset", pm_mode, 1);
        chk("R1 busy reset", busy, 0);
        chk("R1 pm_req reset", pm_req, 0);
        chk("R1 err reset", err_flag, 0);

        // full chain walk, both directions, latency 3
        lat = 3;
        step(2); step(3); step(2); step(1); step(0);
        chk("R10 inhibit in PDA", periph_inhibit, 1);
        step(1);
        chk("R10 inhibit clear in A", periph_inhibit, 0);

        // R6: skipped positions
        wr(3);
        chk("R6 skip sets err", err_flag, 1);
        chk("R6 skip no request", busy, 0);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
        chk("R8 clear", err_flag, 0);
        step(0);
        wr(3);
        chk("R6 end-to-end refused", err_flag, 1);
        chk("R6 mode kept", ack_mode, 0);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
        wr(2);
        chk("R6 distance two refused", err_flag, 1);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;

        // R7: write of current mode
        wr(0);
        chk("R7 same mode no err", err_flag, 0);
        chk("R7 same mode no busy", busy, 0);

        // R5: write while busy, latency 7
        lat = 7;
        wr(1);
        wr(2);
        chk("R5 busy write err", err_flag, 1);
        chk("R5 request kept", pm_mode, 1);
        wait_idle();
        chk("R5 confirmed first only", ack_mode, 1);

        // R8: clear and refusal in same cycle
        @(negedge clk);
        err_clr = 1; wr_en = 1; wr_mode = 2'd3;
        @(negedge clk);
        err_clr = 0; wr_en = 0;
        chk("R8 refusal wins over clear", err_flag, 1);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;

        // latency 0, write during release phase
        lat = 0;
        wr(2);
        while (!(busy && !pm_req)) @(negedge clk);
        wr_en = 1; wr_mode = 2'd3;
        @(negedge clk); wr_en = 0;
        chk("R4 release phase refuses", err_flag, 1);
        wait_idle();
        chk("R3 lat0 confirmed", ack_mode, 2);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;

        // R11: idle acknowledge pulse ignored
        @(negedge clk); poke = 1; @(negedge clk); poke = 0;
        repeat (SYNC + 3) @(negedge clk);
        chk("R11 idle ack ignored", ack_mode, 2);
        chk("R11 idle ack no busy", busy, 0);
        step(3);
        chk("R9 supply low in PDLP", pm_supply_active, 0);
        step(2);
        chk("R9 supply high in LP", pm_supply_active, 1);

        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end

endmodule